// File: doc/BRIEF.md
# Stack Push Store Sequencer

This block takes one push-to-stack opcode and turns it into the sequence of word stores it implies. It recognises one compact 16-bit push form and four 32-bit push forms. Each form has its own way of building a 16-entry register list and its own legality rule. A legal instruction whose condition passes is stored one register per accepted memory write. The lowest register goes to the lowest address. The stack pointer is then written back once, lowered by four bytes per stored register.

The host presents the opcode with a one-cycle valid strobe, along with the current stack pointer, program counter and a condition-pass flag. The block reads register contents through an index/data read port and writes memory through a word port that waits on a ready signal. It ends every accepted opcode with a single-cycle done pulse or a single-cycle error pulse. A strobe is taken only while the block is idle.

Top module: `push_store_seq`

## Requirements
- R1: With compact_i=1, op_i[15:0] matches when (op_i[15:0] & 0xFE00) == 0xB400, and op_i[31:16] is ignored. Its list is op_i[7:0] for r0..r7, plus r14 when op_i[8]=1. An empty list is illegal.
- R2: With compact_i=0, an opcode with (op_i & 0xFFFF0000) == 0xE8AD0000 takes op_i[15:0] as its list, with bits 15 and 13 cleared. A list of fewer than two registers is illegal.
- R3: With compact_i=0, an opcode with (op_i & 0xFFFF0FFF) == 0xF84D0D04 stores the single register named by op_i[15:12]. That index is illegal when it is 13 or 15.
- R4: With compact_i=0, an opcode with (op_i & 0x0FFF0000) == 0x092D0000 takes op_i[15:0] unchanged as its list. An empty list makes no store and writes the stack pointer back unchanged.
- R5: With compact_i=0, an opcode with (op_i & 0x0FFF0FFF) == 0x052D0004 stores the single register named by op_i[15:12]. That index is illegal when it is 13; index 15 is legal.
- R6: An opcode that matches none of the patterns allowed for its compact_i value is illegal.
- R7: Stores go in ascending register index order to consecutive ascending word addresses. The first address is sp_i minus 4 times the list size. The data of register i is read through rf_idx_o / rf_data_i.
- R8: When r15 is in the list, the data of its slot, which is the last one, is pc_i + 8.
- R9: In the cycle after the last accepted store, sp_we_o and done_o are both high for one cycle, and sp_wdata_o equals sp_i minus 4 times the list size.
- R10: When cond_pass_i is low at acceptance, done_o is high in the next cycle with no memory write and no stack-pointer write. This holds even for an illegal opcode.
- R11: While mem_we_o is high and mem_ready_i is low, address, index and data hold. The block moves on to the next slot only on a cycle with mem_ready_i high.
- R12: An illegal opcode with its condition passing raises err_o for exactly one cycle, in the cycle after acceptance, with no writes. done_o and err_o are never high together.
- R13: op_valid_i pulses while an instruction is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Opcode strobe, taken while idle |
| op_i | input | 32 | Opcode; compact form in bits 15:0 |
| compact_i | input | 1 | 1 selects the 16-bit form, 0 the 32-bit forms |
| cond_pass_i | input | 1 | Condition result for this opcode |
| sp_i | input | 32 | Stack pointer at acceptance |
| pc_i | input | 32 | Program counter at acceptance |
| rf_idx_o | output | 4 | Register file read index |
| rf_data_i | input | 32 | Register file read data |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Byte address of the word write |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the current write |
| sp_we_o | output | 1 | Stack pointer writeback strobe |
| sp_wdata_o | output | 32 | New stack pointer |
| done_o | output | 1 | Instruction finished (one cycle) |
| err_o | output | 1 | Illegal encoding (one cycle) |

## Verification
The bench targets several corner cases:
- The compact form with only the link-register bit set, which a decoder missing that bit would reject as empty.
- A wide list carrying bits 13 and 15, which a missed mask would turn into extra stores at shifted addresses.
- Single-register forms naming 13 or 15, which separate the two forms' differing legality rules.
- A full sixteen-register list ending in r15, where a missing +8 bias or a count overflow corrupts the last slot or the stack pointer.
- An empty list in the form that allows one.

Random ready stalls expose a sequencer that advances without a handshake. Condition-failed and illegal opcodes expose a block that writes anything before its completion pulse. Stray strobes during a store expose a block that restarts mid-sequence.

// File: rtl/push_pkg.sv
package push_pkg;
  localparam int unsigned REG_CNT = 16;
  localparam int unsigned SP_REG  = 13;
  localparam int unsigned LR_REG  = 14;
  localparam int unsigned PC_REG  = 15;

  typedef enum logic [2:0] {
    FORM_NONE, FORM_C16, FORM_WMUL, FORM_WONE, FORM_AMUL, FORM_AONE
  } form_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STORE, ST_SPWB, ST_DONE, ST_ERR
  } state_e;

  typedef struct packed {
    form_e               form;
    logic                illegal;
    logic [REG_CNT-1:0]  regs;
  } dec_t;
endpackage

// File: rtl/push_decode.sv
module push_decode
  import push_pkg::*;
#(
  parameter int unsigned CW = $clog2(REG_CNT + 1)
) (
  input  logic [31:0]   op_i,
  input  logic          compact_i,
  output dec_t          dec_o,
  output logic [CW-1:0] cnt_o
);
  logic m_c16, m_wmul, m_wone, m_amul, m_aone;
  logic [3:0] rt;
  logic [REG_CNT-1:0] one_hot;

  assign rt      = op_i[15:12];
  assign one_hot = REG_CNT'(1) << rt;

  assign m_c16  =  compact_i && ((op_i[15:0] & 16'hFE00) == 16'hB400);
  assign m_wmul = !compact_i && ((op_i & 32'hFFFF0000) == 32'hE8AD0000);
  assign m_wone = !compact_i && ((op_i & 32'hFFFF0FFF) == 32'hF84D0D04);
  assign m_amul = !compact_i && ((op_i & 32'h0FFF0000) == 32'h092D0000);
  assign m_aone = !compact_i && ((op_i & 32'h0FFF0FFF) == 32'h052D0004);

  always_comb begin
    dec_o = '{form: FORM_NONE, illegal: 1'b1, regs: '0};
    cnt_o = '0;
    if (m_c16) begin
      dec_o.form          = FORM_C16;
      dec_o.regs[7:0]     = op_i[7:0];
      dec_o.regs[LR_REG]  = op_i[8];
    end else if (m_wmul) begin
      dec_o.form          = FORM_WMUL;
      dec_o.regs          = op_i[15:0];
      dec_o.regs[PC_REG]  = 1'b0;
      dec_o.regs[SP_REG]  = 1'b0;
    end else if (m_wone) begin
      dec_o.form = FORM_WONE;
      dec_o.regs = one_hot;
    end else if (m_amul) begin
      dec_o.form = FORM_AMUL;
      dec_o.regs = op_i[15:0];
    end else if (m_aone) begin
      dec_o.form = FORM_AONE;
      dec_o.regs = one_hot;
    end
    for (int i = 0; i < REG_CNT; i++) cnt_o = cnt_o + CW'(dec_o.regs[i]);
    unique case (dec_o.form)
      FORM_C16:  dec_o.illegal = (cnt_o == '0);
      FORM_WMUL: dec_o.illegal = (cnt_o < CW'(2));
      FORM_WONE: dec_o.illegal = (rt == 4'(SP_REG)) || (rt == 4'(PC_REG));
      FORM_AMUL: dec_o.illegal = 1'b0;
      FORM_AONE: dec_o.illegal = (rt == 4'(SP_REG));
      default:   dec_o.illegal = 1'b1;
    endcase
  end

  // R6
  always_comb begin
    form_disjoint_chk: assert ($onehot0({m_c16, m_wmul, m_wone, m_amul, m_aone}));
  end
endmodule

// File: rtl/push_lowbit.sv
module push_lowbit #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign last_o = $onehot(vec_i);
endmodule

// File: rtl/push_seq.sv
module push_seq
  import push_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned PC_BIAS    = 8,
  parameter int unsigned CW         = $clog2(REG_CNT + 1),
  parameter int unsigned IW         = $clog2(REG_CNT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic            cond_pass_i,
  input  dec_t            dec_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [IW-1:0]   rf_idx_o,
  input  logic [XLEN-1:0] rf_data_i,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic            mem_ready_i,
  output logic            sp_we_o,
  output logic [XLEN-1:0] sp_wdata_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int unsigned SHIFT = $clog2(WORD_BYTES);

  state_e             state_q;
  logic [REG_CNT-1:0] mask_q;
  logic [XLEN-1:0]    addr_q, sp_new_q, pc_q;
  logic [IW-1:0]      cur_idx;
  logic               cur_last;
  logic               accept;
  logic [XLEN-1:0]    sp_base;

  push_lowbit #(.W(REG_CNT), .IW(IW)) i_lowbit (
    .vec_i (mask_q),
    .idx_o (cur_idx),
    .last_o(cur_last)
  );

  assign accept  = (state_q == ST_IDLE) && op_valid_i;
  assign sp_base = sp_i - (XLEN'(cnt_i) << SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      addr_q   <= '0;
      sp_new_q <= '0;
      pc_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          pc_q     <= pc_i;
          sp_new_q <= sp_base;
          addr_q   <= sp_base;
          mask_q   <= dec_i.regs;
          if (!cond_pass_i)          state_q <= ST_DONE;
          else if (dec_i.illegal)    state_q <= ST_ERR;
          else if (cnt_i == '0)      state_q <= ST_SPWB;
          else                       state_q <= ST_STORE;
        end
        ST_STORE: if (mem_ready_i) begin
          mask_q[cur_idx] <= 1'b0;
          addr_q          <= addr_q + XLEN'(WORD_BYTES);
          if (cur_last) state_q <= ST_SPWB;
        end
        default: begin
          mask_q  <= '0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign rf_idx_o    = cur_idx;
  assign mem_we_o    = (state_q == ST_STORE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = (cur_idx == IW'(PC_REG)) ? pc_q + XLEN'(PC_BIAS) : rf_data_i;
  assign sp_we_o     = (state_q == ST_SPWB);
  assign sp_wdata_o  = sp_new_q;
  assign done_o      = (state_q == ST_SPWB) || (state_q == ST_DONE);
  assign err_o       = (state_q == ST_ERR);

  // R11
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !mem_ready_i |=> mem_we_o && $stable(mem_addr_o) && $stable(rf_idx_o));
  // R7
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_ready_i && !cur_last |=>
      mem_we_o && (mem_addr_o == $past(mem_addr_o) + XLEN'(WORD_BYTES)));
  // R9
  last_store_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_ready_i && cur_last |=> sp_we_o && done_o && !mem_we_o);
  // R10
  cond_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !cond_pass_i |=> done_o && !mem_we_o && !sp_we_o);
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !err_o);
  // R12
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o && !mem_we_o && !sp_we_o);
endmodule

// File: rtl/push_store_seq.sv
module push_store_seq
  import push_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned PC_BIAS    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [31:0]     op_i,
  input  logic            compact_i,
  input  logic            cond_pass_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [3:0]      rf_idx_o,
  input  logic [XLEN-1:0] rf_data_i,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic            mem_ready_i,
  output logic            sp_we_o,
  output logic [XLEN-1:0] sp_wdata_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int unsigned CW = $clog2(REG_CNT + 1);

  dec_t          dec;
  logic [CW-1:0] cnt;

  push_decode #(.CW(CW)) i_decode (
    .op_i     (op_i),
    .compact_i(compact_i),
    .dec_o    (dec),
    .cnt_o    (cnt)
  );

  push_seq #(
    .XLEN(XLEN), .WORD_BYTES(WORD_BYTES), .PC_BIAS(PC_BIAS), .CW(CW), .IW(4)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .cond_pass_i(cond_pass_i),
    .dec_i      (dec),
    .cnt_i      (cnt),
    .sp_i       (sp_i),
    .pc_i       (pc_i),
    .rf_idx_o   (rf_idx_o),
    .rf_data_i  (rf_data_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i),
    .sp_we_o    (sp_we_o),
    .sp_wdata_o (sp_wdata_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );
endmodule

// File: tb/test_push_store_seq.sv
module test_push_store_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [31:0] op = '0;
  logic        compact = 1'b0;
  logic        cond = 1'b1;
  logic [31:0] sp = '0, pc = '0;
  logic [3:0]  rf_idx;
  logic [31:0] rf_data;
  logic        mem_we, mem_ready = 1'b0, sp_we, done, err;
  logic [31:0] mem_addr, mem_wdata, sp_wdata;
  logic [31:0] salt = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign rf_data = {salt[27:0], rf_idx};

  push_store_seq i_push_store_seq (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .compact_i(compact), .cond_pass_i(cond), .sp_i(sp), .pc_i(pc),
    .rf_idx_o(rf_idx), .rf_data_i(rf_data), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .sp_we_o(sp_we), .sp_wdata_o(sp_wdata), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Independent reference decode of the requirement text
  function automatic void ref_decode(input bit cmp, input logic [31:0] o,
                                     output logic [15:0] regs, output bit bad);
    logic [3:0] t;
    t = o[15:12];
    regs = '0;
    bad = 1'b0;
    if (cmp) begin
      if (o[15:9] == 7'b1011010) begin
        regs[7:0] = o[7:0];
        regs[14]  = o[8];
        bad = (regs == 16'h0);
      end else bad = 1'b1;
    end else if (o[31:16] == 16'hE8AD) begin
      regs = o[15:0] & 16'h5FFF;
      bad = ($countones(regs) < 2);
    end else if (o[31:16] == 16'hF84D && o[11:0] == 12'hD04) begin
      regs = 16'h1 << t;
      bad = (t == 4'd13) || (t == 4'd15);
    end else if (o[27:16] == 12'h92D) begin
      regs = o[15:0];
    end else if (o[27:16] == 12'h52D && o[11:0] == 12'h004) begin
      regs = 16'h1 << t;
      bad = (t == 4'd13);
    end else bad = 1'b1;
  endfunction

  task automatic run_op(input bit cmp, input logic [31:0] o, input bit c,
                        input logic [31:0] s, input logic [31:0] p,
                        input bit poke, input string req);
    logic [15:0] regs;
    bit bad;
    int cnt, n, guard;
    logic [31:0] base;
    logic [3:0] order [16];
    ref_decode(cmp, o, regs, bad);
    cnt = $countones(regs);
    base = s - 32'(cnt * 4);
    n = 0;
    for (int i = 0; i < 16; i++) if (regs[i]) begin order[n] = 4'(i); n++; end
    n = 0;
    @(negedge clk);
    salt = $urandom;
    compact = cmp; op = o; cond = c; sp = s; pc = p; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    op = $urandom; sp = $urandom; pc = $urandom; cond = $urandom;
    if (!c) begin
      chk(done && !err && !mem_we && !sp_we, {"R10 ", req}, "skip done",
          {28'h0, done, err, mem_we, sp_we}, 32'h8);
    end else if (bad) begin
      chk(err && !done && !mem_we && !sp_we, {"R12 ", req}, "illegal err",
          {28'h0, done, err, mem_we, sp_we}, 32'h4);
    end else begin
      guard = 0;
      while (n < cnt && guard < 200) begin
        chk(mem_we && !done && !err, {"R7 ", req}, "store active",
            {29'h0, mem_we, done, err}, 32'h4);
        chk(mem_addr == base + 32'(n * 4), {"R7 ", req}, "addr", mem_addr, base + 32'(n * 4));
        chk(mem_wdata == ((order[n] == 4'd15) ? p + 32'd8 : {salt[27:0], order[n]}),
            (order[n] == 4'd15) ? {"R8 ", req} : {"R11 ", req}, "data", mem_wdata,
            (order[n] == 4'd15) ? p + 32'd8 : {salt[27:0], order[n]});
        if (poke && guard == 1) begin
          op_valid = 1'b1; compact = 1'b0; op = 32'hE92D0003; cond = 1'b1;  // R13
        end else op_valid = 1'b0;
        mem_ready = ($urandom % 3) != 0;
        if (mem_ready) n++;
        guard++;
        @(negedge clk);
      end
      op_valid = 1'b0;
      mem_ready = 1'b0;
      chk(sp_we && done && !mem_we, {"R9 ", req}, "writeback strobe",
          {29'h0, sp_we, done, mem_we}, 32'h6);
      chk(sp_wdata == base, {"R9 ", req}, "new sp", sp_wdata, base);
    end
    @(negedge clk);
    chk(!done && !err && !mem_we && !sp_we, poke ? "R13" : "R12", "back to idle",
        {28'h0, done, err, mem_we, sp_we}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 3);
    chk(!mem_we && !sp_we && !done && !err, "R12", "reset outputs",
        {28'h0, mem_we, sp_we, done, err}, 32'h0);
    rst_n = 1'b1;
    // directed corners
    run_op(1'b1, 32'hFFFF_B500, 1'b1, 32'h1000, 32'h40, 1'b0, "R1");  // link reg only
    run_op(1'b1, 32'h0000_B400, 1'b1, 32'h1000, 32'h40, 1'b0, "R1");  // empty
    run_op(1'b1, 32'h0000_B5FF, 1'b1, 32'h2000, 32'h40, 1'b0, "R1");
    run_op(1'b0, 32'hE8AD_A001, 1'b1, 32'h3000, 32'h80, 1'b0, "R2");  // forced bits -> one reg
    run_op(1'b0, 32'hE8AD_FFFF, 1'b1, 32'h3000, 32'h80, 1'b0, "R2");
    run_op(1'b0, 32'hF84D_DD04, 1'b1, 32'h3000, 32'h80, 1'b0, "R3");
    run_op(1'b0, 32'hF84D_FD04, 1'b1, 32'h3000, 32'h80, 1'b0, "R3");
    run_op(1'b0, 32'hF84D_5D04, 1'b1, 32'h3000, 32'h80, 1'b0, "R3");
    run_op(1'b0, 32'hE92D_FFFF, 1'b1, 32'h4000, 32'h1234, 1'b1, "R4");
    run_op(1'b0, 32'hE92D_0000, 1'b1, 32'h4000, 32'h1234, 1'b0, "R4");
    run_op(1'b0, 32'hE52D_D004, 1'b1, 32'h4000, 32'h1234, 1'b0, "R5");
    run_op(1'b0, 32'hE52D_F004, 1'b1, 32'h4000, 32'h1234, 1'b0, "R5");
    run_op(1'b0, 32'h0000_B4FF, 1'b1, 32'h4000, 32'h1234, 1'b0, "R6");  // compact pattern in wide mode
    run_op(1'b1, 32'h0000_1234, 1'b1, 32'h4000, 32'h1234, 1'b0, "R6");
    run_op(1'b0, 32'hDEAD_BEEF, 1'b0, 32'h4000, 32'h1234, 1'b0, "R10");
    run_op(1'b0, 32'hE92D_00F0, 1'b0, 32'h4000, 32'h1234, 1'b0, "R10");
    // random mix
    for (int k = 0; k < 120; k++) begin
      logic [31:0] r, o;
      bit cmp;
      int f;
      string req;
      r = $urandom;
      f = $urandom % 6;
      cmp = 1'b0;
      case (f)
        0: begin cmp = 1'b1; o = {r[31:16], 7'b1011010, r[8:0]}; req = "R1"; end
        1: begin o = {16'hE8AD, r[15:0]}; req = "R2"; end
        2: begin o = {16'hF84D, r[15:12], 12'hD04}; req = "R3"; end
        3: begin o = {r[31:28], 12'h92D, r[15:0]}; req = "R4"; end
        4: begin o = {r[31:28], 12'h52D, r[15:12], 12'h004}; req = "R5"; end
        default: begin cmp = r[0]; o = $urandom; req = "R6"; end
      endcase
      run_op(cmp, o, ($urandom % 8) != 0, $urandom, $urandom, ($urandom % 4) == 0, req);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule